// File: doc/BRIEF.md
# Receive Error Concealment and Sample Hold

This block sits after the line decoder of a digital audio receiver. Each decoded subframe enters as a one-cycle strobe carrying a channel tag and the 28 payload bits of the subframe. The block checks the parity of the payload. When the parity fails it replaces the audio sample with the last good sample of the same channel. It also raises a sticky error flag when the receiver loses lock or when selected channel-status bits change between blocks. While that flag is high it can silence the audio.

At the end of every block the decoder presents the collected channel-status vector together with a strobe. The block keeps the vector of the previous block and compares the two. A change in any monitored bit is handled in the same way as a loss of lock. When the whole vector is identical to the one before, the block emits a one-cycle "status updated" pulse, so that software can trust the stable copy.

After every error cause has gone, the error flag stays high for a programmable number of frames. This keeps downstream logic muted while the stream settles.

Top module: `rx_err_hold`

## Requirements
- R1: A subframe with good parity appears on `out_sample` as payload bits 27..4 (sample MSB at bit 27), with `out_ch` equal to its tag and `out_valid` high, in the clock cycle after the `sf_valid` strobe, unless it is muted by R7.
- R2: Parity is even over payload bits 31..4, so the XOR of those bits must be 0. A subframe that fails this check outputs the last good sample of its channel in place of its own sample. After reset that held value is zero.
- R3: Left (`sf_ch`=0) and right (`sf_ch`=1) keep separate held samples, so a parity failure on one channel never outputs the other channel's value.
- R4: While `locked` is low, `err` is high in the same cycle. It also remains high in the cycles that follow, until R6 releases it.
- R5: At a `blk_end` strobe, if the status vector differs from the previous block in a bit selected by `MON_MASK` (default: bits 7..0 and 27..24), `err` goes high in the next cycle. A difference only in unselected bits does not raise `err`.
- R6: Once lock is present and no status change occurs, `err` stays high until `HOLD_FRAMES` (default 4) right-channel subframes have been received. It goes low in the cycle after the last of them.
- R7: With `mute_en`=1, a subframe accepted while `err` is high outputs a zero sample. With `mute_en`=0, the subframe passes or is held according to R1 and R2.
- R8: `cs_upd` is a one-cycle pulse in the cycle after a `blk_end` whose full 48-bit status vector equals that of the previous block. It is never produced for the first block after reset, nor for the first block after lock is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| locked | input | 1 | Receiver lock indication |
| mute_en | input | 1 | Zero the samples while the error flag is high |
| sf_valid | input | 1 | One-cycle strobe: a subframe is present |
| sf_ch | input | 1 | Channel tag: 0 left, 1 right |
| sf_word | input | 28 | Subframe bits 31..4: sample in 27..4, flags in 30..28, parity in 31 |
| blk_end | input | 1 | One-cycle strobe: the block's status vector is complete |
| blk_cs | input | 48 | Channel-status vector of the finished block |
| out_valid | output | 1 | Output sample strobe |
| out_ch | output | 1 | Channel of the output sample |
| out_sample | output | 24 | Corrected, held or muted sample |
| err | output | 1 | Error flag |
| cs_upd | output | 1 | Status vector is stable across two blocks |

## Verification
The main function is exercised with clean subframes on both channels, and with corrupted subframes both before and after good data has arrived. The clean subframes show that data passes untouched. The corrupted ones separate a held value from a reset value, and separate per-channel holding from a shared hold. The status path is driven with identical blocks, with blocks that differ only in unmonitored bits, and with blocks that differ in a monitored bit. This distinguishes the update pulse from the error trigger. Error release is checked one frame before and exactly at the hold count, with muting both enabled and disabled, after a status change and after a loss of lock.

// File: rtl/rx_err_hold.sv
module rx_err_hold #(
  parameter int          SW          = 24,
  parameter int          CSW         = 48,
  parameter logic [47:0] MON_MASK    = 48'h0000_0F00_00FF,
  parameter int          HOLD_FRAMES = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           locked,
  input  logic           mute_en,
  input  logic           sf_valid,
  input  logic           sf_ch,
  input  logic [31:4]    sf_word,
  input  logic           blk_end,
  input  logic [CSW-1:0] blk_cs,
  output logic           out_valid,
  output logic           out_ch,
  output logic [SW-1:0]  out_sample,
  output logic           err,
  output logic           cs_upd
);
  localparam int CW = $clog2(HOLD_FRAMES + 1);
  localparam logic [CW-1:0] HOLD_INIT = CW'(HOLD_FRAMES);

  logic [CW-1:0]  hold_cnt;
  logic [SW-1:0]  last_q [2];
  logic [CSW-1:0] prev_cs;
  logic           have_prev;

  wire          par_bad = ^sf_word;
  wire [SW-1:0] sample  = sf_word[4 +: SW];
  wire          cmp_ok  = blk_end && locked && have_prev;
  wire          cs_chg  = cmp_ok && |((blk_cs ^ prev_cs) & MON_MASK[CSW-1:0]);

  assign err = !locked || (hold_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
    end else if (!locked || cs_chg) begin
      hold_cnt <= HOLD_INIT;
    end else if (sf_valid && sf_ch && hold_cnt != '0) begin
      hold_cnt <= hold_cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q[0]  <= '0;
      last_q[1]  <= '0;
      out_valid  <= 1'b0;
      out_ch     <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= sf_valid;
      if (sf_valid) begin
        out_ch <= sf_ch;
        if (!par_bad) last_q[sf_ch] <= sample;
        if (mute_en && err)  out_sample <= '0;
        else if (par_bad)    out_sample <= last_q[sf_ch];
        else                 out_sample <= sample;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cs   <= '0;
      have_prev <= 1'b0;
      cs_upd    <= 1'b0;
    end else begin
      cs_upd <= cmp_ok && (blk_cs == prev_cs);
      if (!locked) begin
        have_prev <= 1'b0;
      end else if (blk_end) begin
        prev_cs   <= blk_cs;
        have_prev <= 1'b1;
      end
    end
  end

  a_r1_pass: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid && !par_bad && !(mute_en && err) |=> out_valid && out_sample == $past(sample));
  a_r3_hold_own_ch: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid && par_bad && !(mute_en && err) |=> out_sample == $past(last_q[sf_ch]) && out_ch == $past(sf_ch));
  a_r4_unlock_err: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> err);
  a_r5_cs_err: assert property (@(posedge clk) disable iff (!rst_n)
    cs_chg |=> err && !cs_upd);
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> locked && $past(sf_valid && sf_ch));
  a_r7_mute: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid && mute_en && err |=> out_sample == '0);
  a_r8_upd_src: assert property (@(posedge clk) disable iff (!rst_n)
    cs_upd |-> $past(blk_end && locked));
endmodule

// File: tb/rx_err_hold_tb.sv
module rx_err_hold_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        locked = 1'b1;
  logic        mute_en = 1'b0;
  logic        sf_valid = 1'b0;
  logic        sf_ch = 1'b0;
  logic [31:4] sf_word = '0;
  logic        blk_end = 1'b0;
  logic [47:0] blk_cs = '0;
  logic        out_valid, out_ch, err, cs_upd;
  logic [23:0] out_sample;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [24:0] exp_q [$];

  always #10 clk = ~clk;

  rx_err_hold u_dut (.clk(clk), .rst_n(rst_n), .locked(locked), .mute_en(mute_en),
    .sf_valid(sf_valid), .sf_ch(sf_ch), .sf_word(sf_word), .blk_end(blk_end),
    .blk_cs(blk_cs), .out_valid(out_valid), .out_ch(out_ch), .out_sample(out_sample),
    .err(err), .cs_upd(cs_upd));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input bit ch, input logic [23:0] s, input logic [2:0] aux,
                      input bit corrupt, input logic [23:0] exp);
    logic [31:4] w;
    w = {1'b0, aux, s};
    w[31] = (^w[30:4]) ^ corrupt;
    @(negedge clk);
    sf_valid = 1'b1; sf_ch = ch; sf_word = w;
    exp_q.push_back({ch, exp});
    @(negedge clk);
    sf_valid = 1'b0;
  endtask

  task automatic block(input logic [47:0] cs, input bit exp_upd, input string req);
    @(negedge clk);
    blk_end = 1'b1; blk_cs = cs;
    @(negedge clk);
    blk_end = 1'b0;
    chk(cs_upd == exp_upd, req, cs_upd, exp_upd);
    @(negedge clk);
    chk(cs_upd == 1'b0, "R8 pulse width", cs_upd, 0);
  endtask

  always @(negedge clk) begin
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R1 unexpected output", {7'd0, out_ch, out_sample}, 0);
      end else begin
        logic [24:0] e;
        e = exp_q.pop_front();
        chk({out_ch, out_sample} == e, "R1/R2/R3/R7 sample", {7'd0, out_ch, out_sample}, {7'd0, e});
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    logic [47:0] cs0;
    cs0 = 48'h1234_5678_9ABC;
    repeat (3) @(negedge clk);
    chk(!out_valid && !err && !cs_upd, "reset state", {out_valid, err, cs_upd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(err == 1'b0, "R4 locked no err", err, 0);
    // R2: corrupted before any good data -> zero
    send(0, 24'h0ABCDE, 3'b000, 1, 24'h0);
    // R1: clean data, both channels, various flag bits
    send(0, 24'h111111, 3'b101, 0, 24'h111111);
    send(1, 24'h222222, 3'b010, 0, 24'h222222);
    // R3: each channel holds its own value
    send(0, 24'hFFFFFF, 3'b111, 1, 24'h111111);
    send(1, 24'h000001, 3'b001, 1, 24'h222222);
    send(0, 24'h800001, 3'b110, 0, 24'h800001);
    send(0, 24'h5A5A5A, 3'b000, 1, 24'h800001);
    // R8 status stability
    block(cs0, 0, "R8 first block no upd");
    block(cs0, 1, "R8 identical upd");
    chk(err == 1'b0, "R5 no err on match", err, 0);
    block(cs0 ^ 48'h0100_0000_0000, 0, "R8 differ no upd");
    chk(err == 1'b0, "R5 unmonitored change no err", err, 0);
    block(cs0 ^ 48'h0100_0000_0004, 0, "R8 monitored differ no upd");
    chk(err == 1'b1, "R5 monitored change err", err, 1);
    // R7: mute disabled passes, enabled zeroes; R6 counting
    send(0, 24'h333333, 3'b000, 0, 24'h333333);
    mute_en = 1'b1;
    send(0, 24'h444444, 3'b000, 0, 24'h0);
    for (int i = 0; i < 3; i++) send(1, 24'h555555, 3'b000, 0, 24'h0);
    chk(err == 1'b1, "R6 err held one frame early", err, 1);
    send(1, 24'h666666, 3'b000, 0, 24'h0);
    chk(err == 1'b0, "R6 err released at count", err, 0);
    send(0, 24'h777777, 3'b000, 0, 24'h777777);
    // R4 unlock
    @(negedge clk);
    locked = 1'b0;
    #1 chk(err == 1'b1, "R4 unlock err immediate", err, 1);
    send(0, 24'h888888, 3'b000, 0, 24'h0);
    send(1, 24'h999999, 3'b000, 0, 24'h0);
    @(negedge clk);
    locked = 1'b1;
    #1 chk(err == 1'b1, "R4 err stays after relock", err, 1);
    block(cs0, 0, "R8 no upd after unlock");
    for (int i = 0; i < 3; i++) send(1, 24'hAAAAAA, 3'b000, 0, 24'h0);
    chk(err == 1'b1, "R6 still held", err, 1);
    send(1, 24'hBBBBBB, 3'b000, 0, 24'h0);
    chk(err == 1'b0, "R6 released after relock", err, 0);
    send(1, 24'hCCCCCC, 3'b011, 0, 24'hCCCCCC);
    send(1, 24'h123456, 3'b000, 1, 24'hCCCCCC);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all outputs seen", exp_q.size(), 0);
    summary();
  end
endmodule